// File: doc/BRIEF.md
# Host-Visible Serial Line Status Emulator

This block holds the eight-bit line status byte of a 16550-style serial port whose behaviour is produced by a local processor rather than by real serial hardware. Two agents share each flag. Local firmware raises the error flags through register writes. It feeds in events from the emulated receive buffer and transmit holding register, and it reads the live status word. A host reads the same byte through its own strobe, and that read clears the sticky error flags.

Overrun is detected inside the block. A counter of error-carrying bytes in the receive FIFO drives the summary error bit. When a host read and a local set of the same flag land in the same clock cycle, the set is kept and the host sees the value from before the set. Each host read strobe clears the flags once, on its rising edge, after the byte has been captured. The strobe can optionally pass through a synchronizer chain first.

Top module: `uart_lsr_emu`

## Requirements
- R1: The status byte is packed as bit 7 FIFO error summary, bit 6 transmitter empty, bit 5 holding register empty, bit 4 break, bit 3 framing error, bit 2 parity error, bit 1 overrun and bit 0 data ready. It is visible both on `loc_status` and in the captured host byte.
- R2: A local write (`loc_wr_en`) with bit 4, 3 or 2 of `loc_wr_data` at 1 sets the matching flag. A 0 in those positions has no effect. Each of these flags is cleared by a host status read.
- R3: Overrun (bit 1) is set when `rbr_wr` pulses while an earlier byte is still unread, that is, with no `rx_pop` since the previous `rbr_wr` and none in the same cycle. A host status read clears it.
- R4: Data ready (bit 0) is set by `rbr_wr` and cleared in a cycle where `rx_empty` is 1 and no `rbr_wr` occurs.
- R5: On a local write, transmitter empty (bit 6) takes the value of `loc_wr_data[6]`. No other event changes it.
- R6: Holding register empty (bit 5) is set by `thr_drain` and cleared by `thr_load`. When both occur in the same cycle, `thr_drain` wins.
- R7: Bit 7 is 1 while the count of error bytes in the FIFO is nonzero. `rbr_wr` together with `rbr_push_err` increments the count, saturating at FIFO_DEPTH. `rx_pop` together with `rx_pop_err` decrements it, stopping at zero.
- R8: After reset the status byte reads 0x60.
- R9: `host_rd_data` is loaded with the status byte from the cycle of the strobe's rising edge. If a local set and a host clear hit the same flag in that cycle, the flag ends up set.
- R10: A host strobe held high for several cycles clears flags only once, at its rising edge. A flag set later, while the strobe is still high, remains set.
- R11: Bits 7, 5, 1 and 0 of `loc_wr_data` are ignored on local writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_wr_en | input | 1 | Local write strobe to the status register |
| loc_wr_data | input | 8 | Local write data |
| loc_status | output | 8 | Live status byte for local reads |
| rbr_wr | input | 1 | Local write of a byte into the receive buffer/FIFO |
| rbr_push_err | input | 1 | The byte written with `rbr_wr` carries an error |
| rx_pop | input | 1 | Host has taken a byte from the receive buffer/FIFO |
| rx_pop_err | input | 1 | The byte popped with `rx_pop` carried an error |
| rx_empty | input | 1 | Receive buffer/FIFO is empty |
| thr_load | input | 1 | Host placed a byte in the transmit holding register |
| thr_drain | input | 1 | Local processor read or drained the holding register |
| host_rd_stb | input | 1 | Host status read strobe, level |
| host_rd_data | output | 8 | Status byte captured at the host read |

## Verification
The bench builds the block with FIFO_DEPTH of 4 and RD_SYNC_STAGES of 0. With no synchronizer, each host read completes one edge after the strobe rises. This puts the same-cycle collision between a host clear and a local set within exact cycle control. The small depth keeps the error-byte counter within reach of a handful of pushes and pops. The scoreboard predicts every captured host byte from the flag rules alone, including the stretched strobe and the pre-set value returned during a collision.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;

   localparam int LSR_W = 8;

   localparam int BIT_DR   = 0;
   localparam int BIT_OE   = 1;
   localparam int BIT_PE   = 2;
   localparam int BIT_FE   = 3;
   localparam int BIT_BI   = 4;
   localparam int BIT_THRE = 5;
   localparam int BIT_TEMT = 6;
   localparam int BIT_FERR = 7;

   // number of firmware-set sticky error flags (break, framing, parity)
   localparam int N_STICKY = 3;

   typedef struct packed {
      logic fifo_err;
      logic tx_empty;
      logic thr_empty;
      logic brk;
      logic frm;
      logic par;
      logic ovr;
      logic rdy;
   } lsr_t;

   localparam lsr_t LSR_RESET = '{fifo_err: 1'b0, tx_empty: 1'b1,
                                  thr_empty: 1'b1, brk: 1'b0, frm: 1'b0,
                                  par: 1'b0, ovr: 1'b0, rdy: 1'b0};

   // bit position of sticky flag k
   function automatic int sticky_bit(input int k);
      return BIT_PE + k;
   endfunction

endpackage

// File: rtl/lsr_rd_edge.sv
module lsr_rd_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb_i,
   output logic rise_o
);

   logic stb_s;
   logic stb_prev;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign stb_s = stb_i;
      end else if (SYNC_STAGES >= 2) begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SYNC_STAGES-2:0], stb_i};
         end
         assign stb_s = chain[SYNC_STAGES-1];
      end else begin : g_bad
         $error("lsr_rd_edge: SYNC_STAGES must be 0 or at least 2");
         assign stb_s = stb_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) stb_prev <= 1'b0;
      else        stb_prev <= stb_s;
   end

   assign rise_o = stb_s & ~stb_prev;

endmodule

// File: rtl/lsr_err_tracker.sv
module lsr_err_tracker #(
   parameter int FIFO_DEPTH = 16,
   localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push_i,
   input  logic push_err_i,
   input  logic pop_i,
   input  logic pop_err_i,
   output logic any_err_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FIFO_DEPTH);

   logic [CNT_W-1:0] cnt_q;
   logic inc, dec;

   assign inc = push_i & push_err_i & (cnt_q != CNT_MAX);
   assign dec = pop_i  & pop_err_i  & (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         unique case ({inc, dec})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign any_err_o = (cnt_q != '0);

endmodule

// File: rtl/lsr_flag_bank.sv
module lsr_flag_bank
   import uart_lsr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [LSR_W-1:0] wr_data_i,
   input  logic             rd_clr_i,
   input  logic             rbr_wr_i,
   input  logic             rx_pop_i,
   input  logic             rx_empty_i,
   input  logic             thr_load_i,
   input  logic             thr_drain_i,
   output logic [N_STICKY-1:0] sticky_o,
   output logic             ovr_o,
   output logic             rdy_o,
   output logic             thre_o,
   output logic             temt_o,
   output logic             unread_o
);

   // firmware-set, host-cleared flags; a set in the clearing cycle wins
   genvar k;
   generate
      for (k = 0; k < N_STICKY; k++) begin : g_sticky
         logic q;
         logic set;
         assign set = wr_en_i & wr_data_i[sticky_bit(k)];
         always_ff @(posedge clk) begin
            if (!rst_n)        q <= 1'b0;
            else if (set)      q <= 1'b1;
            else if (rd_clr_i) q <= 1'b0;
         end
         assign sticky_o[k] = q;
      end
   endgenerate

   // a byte is unread from its write until the host pops one
   logic unread_q;
   always_ff @(posedge clk) begin
      if (!rst_n)        unread_q <= 1'b0;
      else if (rbr_wr_i) unread_q <= 1'b1;
      else if (rx_pop_i) unread_q <= 1'b0;
   end
   assign unread_o = unread_q;

   logic ovr_q, ovr_set;
   assign ovr_set = rbr_wr_i & unread_q & ~rx_pop_i;
   always_ff @(posedge clk) begin
      if (!rst_n)        ovr_q <= 1'b0;
      else if (ovr_set)  ovr_q <= 1'b1;
      else if (rd_clr_i) ovr_q <= 1'b0;
   end
   assign ovr_o = ovr_q;

   logic rdy_q;
   always_ff @(posedge clk) begin
      if (!rst_n)          rdy_q <= 1'b0;
      else if (rbr_wr_i)   rdy_q <= 1'b1;
      else if (rx_empty_i) rdy_q <= 1'b0;
   end
   assign rdy_o = rdy_q;

   logic thre_q;
   always_ff @(posedge clk) begin
      if (!rst_n)           thre_q <= LSR_RESET.thr_empty;
      else if (thr_drain_i) thre_q <= 1'b1;
      else if (thr_load_i)  thre_q <= 1'b0;
   end
   assign thre_o = thre_q;

   logic temt_q;
   always_ff @(posedge clk) begin
      if (!rst_n)       temt_q <= LSR_RESET.tx_empty;
      else if (wr_en_i) temt_q <= wr_data_i[BIT_TEMT];
   end
   assign temt_o = temt_q;

endmodule

// File: rtl/uart_lsr_emu.sv
module uart_lsr_emu
   import uart_lsr_pkg::*;
#(
   parameter int FIFO_DEPTH     = 16,
   parameter int RD_SYNC_STAGES = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       loc_wr_en,
   input  logic [7:0] loc_wr_data,
   output logic [7:0] loc_status,
   input  logic       rbr_wr,
   input  logic       rbr_push_err,
   input  logic       rx_pop,
   input  logic       rx_pop_err,
   input  logic       rx_empty,
   input  logic       thr_load,
   input  logic       thr_drain,
   input  logic       host_rd_stb,
   output logic [7:0] host_rd_data
);

   generate
      if (FIFO_DEPTH < 1) begin : g_bad_depth
         $error("uart_lsr_emu: FIFO_DEPTH must be at least 1");
      end
   endgenerate

   logic rd_rise;
   logic err_any;
   logic [N_STICKY-1:0] sticky;
   logic ovr, rdy, thre, temt, rx_unread;
   lsr_t status;

   lsr_rd_edge #(.SYNC_STAGES(RD_SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb_i  (host_rd_stb),
      .rise_o (rd_rise)
   );

   lsr_err_tracker #(.FIFO_DEPTH(FIFO_DEPTH)) u_err (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (rbr_wr),
      .push_err_i (rbr_push_err),
      .pop_i      (rx_pop),
      .pop_err_i  (rx_pop_err),
      .any_err_o  (err_any)
   );

   lsr_flag_bank u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en_i     (loc_wr_en),
      .wr_data_i   (loc_wr_data),
      .rd_clr_i    (rd_rise),
      .rbr_wr_i    (rbr_wr),
      .rx_pop_i    (rx_pop),
      .rx_empty_i  (rx_empty),
      .thr_load_i  (thr_load),
      .thr_drain_i (thr_drain),
      .sticky_o    (sticky),
      .ovr_o       (ovr),
      .rdy_o       (rdy),
      .thre_o      (thre),
      .temt_o      (temt),
      .unread_o    (rx_unread)
   );

   always_comb begin
      status.fifo_err  = err_any;
      status.tx_empty  = temt;
      status.thr_empty = thre;
      status.brk       = sticky[2];
      status.frm       = sticky[1];
      status.par       = sticky[0];
      status.ovr       = ovr;
      status.rdy       = rdy;
   end

   assign loc_status = status;

   // capture before the clear lands on the same edge
   always_ff @(posedge clk) begin
      if (!rst_n)       host_rd_data <= '0;
      else if (rd_rise) host_rd_data <= status;
   end

endmodule

// File: rtl/lsr_chk.sv
module lsr_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       loc_wr_en,
   input logic [7:0] loc_wr_data,
   input logic [7:0] loc_status,
   input logic       rbr_wr,
   input logic       rbr_push_err,
   input logic       rx_pop,
   input logic       thr_drain,
   input logic [7:0] host_rd_data,
   input logic       rd_rise,
   input logic       unread
);

   // R2
   fe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_rise && !(loc_wr_en && loc_wr_data[3]) |=> !loc_status[3]);

   // R3
   overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rbr_wr && unread && !rx_pop |=> loc_status[1]);

   // R4
   data_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rbr_wr |=> loc_status[0]);

   // R5
   temt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loc_wr_en |=> loc_status[6] == $past(loc_wr_data[6]));

   // R6
   thre_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      thr_drain |=> loc_status[5]);

   // R7
   fifo_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rbr_wr && rbr_push_err |=> loc_status[7]);

   // R9
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_rise |=> host_rd_data == $past(loc_status));

endmodule

bind uart_lsr_emu lsr_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .loc_wr_en    (loc_wr_en),
   .loc_wr_data  (loc_wr_data),
   .loc_status   (loc_status),
   .rbr_wr       (rbr_wr),
   .rbr_push_err (rbr_push_err),
   .rx_pop       (rx_pop),
   .thr_drain    (thr_drain),
   .host_rd_data (host_rd_data),
   .rd_rise      (rd_rise),
   .unread       (rx_unread)
);

// File: tb/uart_lsr_emu_tb.sv
module uart_lsr_emu_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       loc_wr_en = 1'b0;
   logic [7:0] loc_wr_data = '0;
   logic [7:0] loc_status;
   logic       rbr_wr = 1'b0, rbr_push_err = 1'b0;
   logic       rx_pop = 1'b0, rx_pop_err = 1'b0, rx_empty = 1'b0;
   logic       thr_load = 1'b0, thr_drain = 1'b0;
   logic       host_rd_stb = 1'b0;
   logic [7:0] host_rd_data;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];
   event       rd_done;

   always #4 clk = ~clk;

   uart_lsr_emu #(.FIFO_DEPTH(4), .RD_SYNC_STAGES(0)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .loc_wr_en(loc_wr_en), .loc_wr_data(loc_wr_data), .loc_status(loc_status),
      .rbr_wr(rbr_wr), .rbr_push_err(rbr_push_err),
      .rx_pop(rx_pop), .rx_pop_err(rx_pop_err), .rx_empty(rx_empty),
      .thr_load(thr_load), .thr_drain(thr_drain),
      .host_rd_stb(host_rd_stb), .host_rd_data(host_rd_data)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // one-cycle local events, status checked after the edge
   task automatic loc_write(input logic [7:0] d);
      @(negedge clk); loc_wr_en = 1'b1; loc_wr_data = d;
      @(negedge clk); loc_wr_en = 1'b0;
   endtask

   task automatic pulse(input bit w, input bit we, input bit p, input bit pe,
                        input bit e, input bit tl, input bit td);
      @(negedge clk);
      rbr_wr = w; rbr_push_err = we; rx_pop = p; rx_pop_err = pe;
      rx_empty = e; thr_load = tl; thr_drain = td;
      @(negedge clk);
      rbr_wr = 0; rbr_push_err = 0; rx_pop = 0; rx_pop_err = 0;
      rx_empty = 0; thr_load = 0; thr_drain = 0;
   endtask

   // host read: strobe held 'hold' cycles, optional local write at cycle wr_at
   task automatic host_read(input logic [7:0] exp, input string tag,
                            input int hold, input int wr_at, input logic [7:0] wd);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         host_rd_stb = 1'b1;
         loc_wr_en = (i == wr_at);
         loc_wr_data = wd;
      end
      @(negedge clk);
      host_rd_stb = 1'b0;
      loc_wr_en = 1'b0;
      ->rd_done;
   endtask

   // monitor: compares each captured host byte against the scoreboard
   initial begin
      forever begin
         @(rd_done);
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R9: host read with empty scoreboard, actual %02h expected none", host_rd_data);
         end else begin
            chk(tag_q.pop_front(), host_rd_data, exp_q.pop_front());
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset value, R1 packing of THRE and TEMT
      chk("R8 reset status", loc_status, 8'h60);
      host_read(8'h60, "R8 R1 reset host byte", 1, -1, 8'h00);

      // R2 break/framing/parity set by writes of 1, cleared by host read
      loc_write(8'h5C);
      chk("R2 sticky set", loc_status, 8'h7C);
      host_read(8'h7C, "R2 R1 pre-clear byte", 1, -1, 8'h00);
      chk("R2 cleared by host read", loc_status, 8'h60);
      loc_write(8'h40);
      chk("R2 zero write no effect", loc_status, 8'h60);

      // R5 TEMT follows bit 6 of local writes
      loc_write(8'h00);
      chk("R5 TEMT cleared", loc_status, 8'h20);
      loc_write(8'h40);
      chk("R5 TEMT set", loc_status, 8'h60);

      // R4 data ready, R3 overrun on double write
      pulse(1, 0, 0, 0, 0, 0, 0);
      chk("R4 data ready set", loc_status, 8'h61);
      pulse(1, 0, 0, 0, 0, 0, 0);
      chk("R3 overrun set", loc_status, 8'h63);
      host_read(8'h63, "R3 overrun in host byte", 1, -1, 8'h00);
      chk("R3 overrun cleared, R4 ready kept", loc_status, 8'h61);
      pulse(0, 0, 1, 0, 1, 0, 0);
      chk("R4 ready cleared on empty", loc_status, 8'h60);

      // R3 no overrun when host pops between writes
      pulse(1, 0, 0, 0, 0, 0, 0);
      pulse(0, 0, 1, 0, 0, 0, 0);
      pulse(1, 0, 0, 0, 0, 0, 0);
      chk("R3 no overrun after pop", loc_status, 8'h61);
      pulse(0, 0, 1, 0, 1, 0, 0);
      chk("R4 drained", loc_status, 8'h60);

      // R6 holding register empty
      pulse(0, 0, 0, 0, 0, 1, 0);
      chk("R6 THRE cleared by load", loc_status, 8'h40);
      pulse(0, 0, 0, 0, 0, 0, 1);
      chk("R6 THRE set by drain", loc_status, 8'h60);
      pulse(0, 0, 0, 0, 0, 1, 0);
      pulse(0, 0, 0, 0, 0, 1, 1);
      chk("R6 drain wins over load", loc_status, 8'h60);

      // R7 error-byte counter drives bit 7
      pulse(1, 1, 0, 0, 0, 0, 0);
      pulse(1, 1, 0, 0, 0, 0, 0);
      chk("R7 bit7 with two error bytes", loc_status, 8'hE3);
      host_read(8'hE3, "R7 R1 host byte with errors", 1, -1, 8'h00);
      pulse(0, 0, 1, 1, 0, 0, 0);
      chk("R7 bit7 kept with one error byte", loc_status, 8'hE1);
      pulse(0, 0, 1, 1, 1, 0, 0);
      chk("R7 bit7 dropped at zero", loc_status, 8'h60);
      pulse(0, 0, 1, 1, 0, 0, 0);
      pulse(1, 0, 0, 0, 0, 0, 0);
      chk("R7 no underflow on extra pop", loc_status, 8'h61);
      pulse(0, 0, 1, 0, 1, 0, 0);
      for (int i = 0; i < 6; i++) pulse(1, 1, 1, 0, 0, 0, 0);
      for (int i = 0; i < 3; i++) pulse(0, 0, 1, 1, 0, 0, 0);
      chk("R7 saturated count still nonzero", loc_status, 8'hE1);
      pulse(0, 0, 1, 1, 1, 0, 0);
      chk("R7 count emptied from saturation", loc_status, 8'h60);

      // R9 collision: clear of PE and set of FE on the same edge
      loc_write(8'h44);
      chk("R9 parity set", loc_status, 8'h64);
      host_read(8'h64, "R9 pre-set byte", 1, 0, 8'h48);
      chk("R9 set wins, parity cleared", loc_status, 8'h68);
      host_read(8'h68, "R9 second read", 1, -1, 8'h00);
      chk("R9 framing cleared", loc_status, 8'h60);

      // R10 held strobe clears once
      loc_write(8'h50);
      host_read(8'h70, "R10 held strobe byte", 4, 2, 8'h50);
      chk("R10 set during hold survives", loc_status, 8'h70);
      host_read(8'h70, "R10 fresh read", 1, -1, 8'h00);
      chk("R10 cleared by new edge", loc_status, 8'h60);

      // R11 read-only positions ignored
      loc_write(8'hE3);
      chk("R11 read-only bits ignored", loc_status, 8'h60);
      host_read(8'h60, "R11 host byte", 1, -1, 8'h00);

      repeat (2) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_cmp++; n_bad++;
         $display("FAIL R9: %0d host reads unchecked, expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule